// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-facing register set of a single DMA channel. A host reaches it through a plain 32-bit register port: offset, write flag, write data and a read-data return. The block stores everything a transfer engine needs to run one transfer: the source and destination addresses, each split into an upper and a lower 32-bit word, the access width and address mode of each side, the bytes per burst, the burst count, the request selector and the interval count. It passes these values out unchanged to the engine. Several channels are built by placing copies in consecutive 256-byte windows, so the offset port is only as wide as one window.

A small control state machine sits behind the start bit. It has three states. In CH_IDLE the channel is stopped. In CH_RUN the engine is requested to transfer. In CH_DRAIN software has aborted the transfer, but the engine still reports busy. The transitions are as follows. Start: CH_IDLE to CH_RUN when the start bit is written to 1. Finish: CH_RUN to CH_IDLE when the engine reports end or error. Abort: CH_RUN to CH_DRAIN when the start bit is written to 0. Settle: CH_DRAIN to CH_IDLE once the engine busy input is low. The status busy bit is high in every state except CH_IDLE, so it only falls after the engine has really stopped.

Two event flags, end and error, are latched from engine pulses. Software clears them by writing 1 to the flag bit. A per-flag enable masks the flags, and the OR of the masked flags drives a level interrupt.

Top module: `dma_chreg_bank`

## Requirements
- R1: After reset every register reads zero and every output is low. A read of an offset with no register (for example 0x00, 0x3C, 0x4C) returns zero.
- R2: Offset 0x08 keeps the request selector in bits [5:0] and the interval count in bits [23:16]. All other bits read zero. Both fields appear on their output ports.
- R3: The source mode register (0x10) and the destination mode register (0x14) each keep an access-width code in bits [25:24] and a fixed-address bit in bit 4. A 1 in bit 4 means a fixed address and a 0 means an incrementing address. All other bits read zero.
- R4: The upper address words are at 0x18 (source) and 0x1C (destination). The lower address words are at 0x20 (source) and 0x24 (destination). The 64-bit address outputs are {upper, lower}.
- R5: The burst-size register (0x28) keeps bits [25:0]. The burst-count register (0x2C) keeps bits [15:0].
- R6: Writing 1 to bit 0 of 0x30 while idle raises run_req on the next cycle. While running, bit 0 of 0x30 and bit 0 of status (0x40) both read 1.
- R7: An end or error pulse while running returns the channel to idle on the next cycle. run_req and the status busy bit then read 0.
- R8: Writing 0 to bit 0 of 0x30 while running drops run_req on the next cycle. The status busy bit stays 1 while eng_busy is high and falls on the cycle after eng_busy is seen low.
- R9: An end pulse sets raw flag bit 0 and an error pulse sets raw flag bit 1 (offset 0x44). Writing 1 to a raw bit clears it. Writing 0 leaves it unchanged.
- R10: When a flag is set by the engine in the same cycle as a clearing write to that flag, the flag ends up set.
- R11: Offset 0x34 holds the enables (bit 0 end, bit 1 error). Offset 0x48 reads the raw flags ANDed with the enables. irq is high exactly when any masked flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset within the channel window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current read access (combinational) |
| eng_busy | input | 1 | Engine is still moving data |
| eng_done | input | 1 | One-cycle end-of-transfer pulse |
| eng_err | input | 1 | One-cycle error pulse |
| src_addr | output | 64 | Source address |
| dst_addr | output | 64 | Destination address |
| src_width | output | 2 | Source access-width code |
| dst_width | output | 2 | Destination access-width code |
| src_fixed | output | 1 | Source address is held fixed |
| dst_fixed | output | 1 | Destination address is held fixed |
| req_sel | output | 6 | Request selector |
| interval_clks | output | 8 | Interval count |
| burst_bytes | output | 26 | Bytes per burst |
| burst_count | output | 16 | Number of bursts |
| run_req | output | 1 | Transfer request to the engine |
| ch_active | output | 1 | Status busy bit |
| irq | output | 1 | Level interrupt |

## Verification
Some rules can be checked on every cycle, and the assertions do that. run_req is never high without the busy status. An end or error pulse always stops a running channel. The drain state holds while eng_busy is high and leaves once it is low. A set raw flag never disappears without a clearing write. An engine pulse always leaves its flag set, even against a clear in the same cycle. Other behaviour is only visible through the bench's scenarios: the bit masks of each register as seen on readback, the split address words forming the 64-bit outputs, the masked-flag view under different enable patterns, and the write-zero cases that must leave flags untouched.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_t;

    localparam logic [7:0] OFS_FACTOR = 8'h08;
    localparam logic [7:0] OFS_SMODE  = 8'h10;
    localparam logic [7:0] OFS_DMODE  = 8'h14;
    localparam logic [7:0] OFS_SHI    = 8'h18;
    localparam logic [7:0] OFS_DHI    = 8'h1C;
    localparam logic [7:0] OFS_SLO    = 8'h20;
    localparam logic [7:0] OFS_DLO    = 8'h24;
    localparam logic [7:0] OFS_BSIZE  = 8'h28;
    localparam logic [7:0] OFS_BCNT   = 8'h2C;
    localparam logic [7:0] OFS_START  = 8'h30;
    localparam logic [7:0] OFS_ENABLE = 8'h34;
    localparam logic [7:0] OFS_STATUS = 8'h40;
    localparam logic [7:0] OFS_RAW    = 8'h44;
    localparam logic [7:0] OFS_MASKED = 8'h48;

    localparam int FLAG_N    = 2;
    localparam int FLAG_DONE = 0;
    localparam int FLAG_ERR  = 1;

    localparam int MODE_FIX_BIT = 4;
    localparam int MODE_W_LSB   = 24;
    localparam int IVL_LSB      = 16;

endpackage

// File: rtl/dma_chreg_ctrl_fsm.sv
module dma_chreg_ctrl_fsm
    import dma_chreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_val,
    input  logic eng_busy,
    input  logic eng_done,
    input  logic eng_err,
    output logic run_req,
    output logic active
);

    ch_state_t st_q;
    ch_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (start_wr && start_val) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (eng_done || eng_err)         st_d = CH_IDLE;
                else if (start_wr && !start_val) st_d = CH_DRAIN;
            end
            CH_DRAIN: begin
                if (!eng_busy) st_d = CH_IDLE;
            end
            default: st_d = CH_IDLE;
        endcase
    end

    always_comb begin
        run_req = (st_q == CH_RUN);
        active  = (st_q != CH_IDLE);
    end

endmodule

// File: rtl/dma_chreg_flags.sv
module dma_chreg_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         en_wr,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] raw,
    output logic [N-1:0] enable,
    output logic [N-1:0] masked,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) raw[i] <= 1'b0;
            else        raw[i] <= set_pulse[i] | (raw[i] & ~(clr_wr & clr_bits[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= en_bits;
    end

    assign masked = raw & enable;
    assign irq    = |masked;

endmodule

// File: rtl/dma_chreg_bank.sv
module dma_chreg_bank
    import dma_chreg_pkg::*;
#(
    parameter int WIN_BYTES = 256,
    parameter int SIZE_W    = 26,
    parameter int CNT_W     = 16,
    parameter int SEL_W     = 6,
    parameter int IVL_W     = 8,
    localparam int OFS_W    = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic [63:0]       src_addr,
    output logic [63:0]       dst_addr,
    output logic [1:0]        src_width,
    output logic [1:0]        dst_width,
    output logic              src_fixed,
    output logic              dst_fixed,
    output logic [SEL_W-1:0]  req_sel,
    output logic [IVL_W-1:0]  interval_clks,
    output logic [SIZE_W-1:0] burst_bytes,
    output logic [CNT_W-1:0]  burst_count,
    output logic              run_req,
    output logic              ch_active,
    output logic              irq
);

    logic [31:0]       s_hi, s_lo, d_hi, d_lo;
    logic [1:0]        s_w, d_w;
    logic              s_fix, d_fix;
    logic [SEL_W-1:0]  sel_q;
    logic [IVL_W-1:0]  ivl_q;
    logic [SIZE_W-1:0] bsz_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [FLAG_N-1:0] raw_flags, en_flags, msk_flags;

    logic wr_en, rd_en;
    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    function automatic logic hit(input logic [OFS_W-1:0] a, input logic [7:0] ofs);
        return a == OFS_W'(ofs);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_hi <= '0; s_lo <= '0; d_hi <= '0; d_lo <= '0;
            s_w <= '0; d_w <= '0; s_fix <= 1'b0; d_fix <= 1'b0;
            sel_q <= '0; ivl_q <= '0; bsz_q <= '0; bcnt_q <= '0;
        end else if (wr_en) begin
            if (hit(req_addr, OFS_FACTOR)) begin
                sel_q <= req_wdata[SEL_W-1:0];
                ivl_q <= req_wdata[IVL_LSB +: IVL_W];
            end
            if (hit(req_addr, OFS_SMODE)) begin
                s_w   <= req_wdata[MODE_W_LSB +: 2];
                s_fix <= req_wdata[MODE_FIX_BIT];
            end
            if (hit(req_addr, OFS_DMODE)) begin
                d_w   <= req_wdata[MODE_W_LSB +: 2];
                d_fix <= req_wdata[MODE_FIX_BIT];
            end
            if (hit(req_addr, OFS_SHI))   s_hi   <= req_wdata;
            if (hit(req_addr, OFS_DHI))   d_hi   <= req_wdata;
            if (hit(req_addr, OFS_SLO))   s_lo   <= req_wdata;
            if (hit(req_addr, OFS_DLO))   d_lo   <= req_wdata;
            if (hit(req_addr, OFS_BSIZE)) bsz_q  <= req_wdata[SIZE_W-1:0];
            if (hit(req_addr, OFS_BCNT))  bcnt_q <= req_wdata[CNT_W-1:0];
        end
    end

    dma_chreg_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (wr_en && hit(req_addr, OFS_START)),
        .start_val (req_wdata[0]),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .run_req   (run_req),
        .active    (ch_active)
    );

    logic [FLAG_N-1:0] set_vec;
    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_DONE] = eng_done;
        set_vec[FLAG_ERR]  = eng_err;
    end

    dma_chreg_flags #(.N(FLAG_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_vec),
        .clr_wr    (wr_en && hit(req_addr, OFS_RAW)),
        .clr_bits  (req_wdata[FLAG_N-1:0]),
        .en_wr     (wr_en && hit(req_addr, OFS_ENABLE)),
        .en_bits   (req_wdata[FLAG_N-1:0]),
        .raw       (raw_flags),
        .enable    (en_flags),
        .masked    (msk_flags),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (hit(req_addr, OFS_FACTOR)) begin
                rd_data[SEL_W-1:0]         = sel_q;
                rd_data[IVL_LSB +: IVL_W]  = ivl_q;
            end
            if (hit(req_addr, OFS_SMODE)) begin
                rd_data[MODE_W_LSB +: 2]   = s_w;
                rd_data[MODE_FIX_BIT]      = s_fix;
            end
            if (hit(req_addr, OFS_DMODE)) begin
                rd_data[MODE_W_LSB +: 2]   = d_w;
                rd_data[MODE_FIX_BIT]      = d_fix;
            end
            if (hit(req_addr, OFS_SHI))    rd_data = s_hi;
            if (hit(req_addr, OFS_DHI))    rd_data = d_hi;
            if (hit(req_addr, OFS_SLO))    rd_data = s_lo;
            if (hit(req_addr, OFS_DLO))    rd_data = d_lo;
            if (hit(req_addr, OFS_BSIZE))  rd_data[SIZE_W-1:0] = bsz_q;
            if (hit(req_addr, OFS_BCNT))   rd_data[CNT_W-1:0]  = bcnt_q;
            if (hit(req_addr, OFS_START))  rd_data[0] = run_req;
            if (hit(req_addr, OFS_ENABLE)) rd_data[FLAG_N-1:0] = en_flags;
            if (hit(req_addr, OFS_STATUS)) rd_data[0] = ch_active;
            if (hit(req_addr, OFS_RAW))    rd_data[FLAG_N-1:0] = raw_flags;
            if (hit(req_addr, OFS_MASKED)) rd_data[FLAG_N-1:0] = msk_flags;
        end
    end

    assign src_addr      = {s_hi, s_lo};
    assign dst_addr      = {d_hi, d_lo};
    assign src_width     = s_w;
    assign dst_width     = d_w;
    assign src_fixed     = s_fix;
    assign dst_fixed     = d_fix;
    assign req_sel       = sel_q;
    assign interval_clks = ivl_q;
    assign burst_bytes   = bsz_q;
    assign burst_count   = bcnt_q;

endmodule

// File: rtl/dma_chreg_bank_chk.sv
module dma_chreg_bank_chk #(
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [OFS_W-1:0] req_addr,
    input logic [31:0]      req_wdata,
    input logic             eng_busy,
    input logic             eng_done,
    input logic             eng_err,
    input logic             run_req,
    input logic             ch_active,
    input logic             irq,
    input logic [1:0]       raw
);

    logic clr0;
    assign clr0 = req_valid && req_write && (req_addr == OFS_W'(8'h44)) && req_wdata[0];

    assert_run_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |-> ch_active);

    assert_pulse_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && (eng_done || eng_err)) |=> !run_req);

    assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_active && !run_req && eng_busy) |=> ch_active);

    assert_drain_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_active && !run_req && !eng_busy) |=> !ch_active);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[0] && !clr0) |=> raw[0]);

    assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> raw[1]);

    assert_done_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> raw[0]);

    assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != 2'b00));

endmodule

bind dma_chreg_bank dma_chreg_bank_chk #(.OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .run_req   (run_req),
    .ch_active (ch_active),
    .irq       (irq),
    .raw       (raw_flags)
);

// File: tb/dma_chreg_bank_test.sv
module dma_chreg_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [63:0] src_addr, dst_addr;
    logic [1:0]  src_width, dst_width;
    logic        src_fixed, dst_fixed;
    logic [5:0]  req_sel;
    logic [7:0]  interval_clks;
    logic [25:0] burst_bytes;
    logic [15:0] burst_count;
    logic        run_req, ch_active, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_chreg_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_width(src_width),
        .dst_width(dst_width), .src_fixed(src_fixed), .dst_fixed(dst_fixed),
        .req_sel(req_sel), .interval_clks(interval_clks), .burst_bytes(burst_bytes),
        .burst_count(burst_count), .run_req(run_req), .ch_active(ch_active), .irq(irq)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse(input bit done, input bit err);
        @(negedge clk);
        eng_done = done; eng_err = err;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    // monitor: compare read data against the scoreboard away from the edge
    always begin
        @(negedge clk);
        #1;
        if (req_valid && !req_write) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=0x%0h expected=item", rd_data);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk($sformatf("%s rd@0x%0h", it.tag, it.addr), {32'b0, rd_data}, {32'b0, it.exp});
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and unmapped offsets
        chk("R1 run_req", run_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 src_addr", src_addr, 0);
        rd(8'h08, 0, "R1");
        rd(8'h30, 0, "R1");
        rd(8'h40, 0, "R1");
        rd(8'h44, 0, "R1");
        rd(8'h00, 0, "R1");
        rd(8'h3C, 0, "R1");

        // R2 factor fields
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h00FF_003F, "R2");
        wr(8'h08, 32'h0014_0025);
        chk("R2 req_sel", req_sel, 6'h25);
        chk("R2 interval", interval_clks, 8'h14);

        // R3 modes
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0300_0010, "R3");
        chk("R3 src_fixed", src_fixed, 1);
        chk("R3 src_width", src_width, 3);
        wr(8'h14, 32'h0100_0000);
        rd(8'h14, 32'h0100_0000, "R3");
        chk("R3 dst_fixed", dst_fixed, 0);
        chk("R3 dst_width", dst_width, 1);

        // R4 split addresses
        wr(8'h20, 32'h89AB_CDEF);
        wr(8'h18, 32'h0123_4567);
        wr(8'h24, 32'h1111_2222);
        wr(8'h1C, 32'hAAAA_5555);
        chk("R4 src_addr", src_addr, 64'h0123_4567_89AB_CDEF);
        chk("R4 dst_addr", dst_addr, 64'hAAAA_5555_1111_2222);
        rd(8'h1C, 32'hAAAA_5555, "R4");

        // R5 size and count
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h28, 32'h03FF_FFFF, "R5");
        rd(8'h2C, 32'h0000_FFFF, "R5");
        chk("R5 burst_bytes", burst_bytes, 26'h3FF_FFFF);

        // R6 start
        wr(8'h30, 1);
        chk("R6 run_req", run_req, 1);
        rd(8'h30, 1, "R6");
        rd(8'h40, 1, "R6");

        // R7 end pulse stops the channel; R9 flag set
        pulse(1, 0);
        chk("R7 run_req", run_req, 0);
        rd(8'h40, 0, "R7");
        rd(8'h44, 1, "R9");
        rd(8'h48, 0, "R11");
        chk("R11 irq masked off", irq, 0);

        // R11 enable end
        wr(8'h34, 1);
        chk("R11 irq", irq, 1);
        rd(8'h48, 1, "R11");

        // R9 write-zero keeps, write-one clears
        wr(8'h44, 0);
        rd(8'h44, 1, "R9");
        wr(8'h44, 1);
        rd(8'h44, 0, "R9");
        chk("R9 irq after clear", irq, 0);

        // R9/R11 error flag with only end enabled
        pulse(0, 1);
        rd(8'h44, 2, "R9");
        rd(8'h48, 0, "R11");
        chk("R11 irq err disabled", irq, 0);
        wr(8'h34, 3);
        chk("R11 irq err enabled", irq, 1);
        rd(8'h48, 2, "R11");

        // R10 set wins over clear in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h44; req_wdata = 2;
        eng_err = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; eng_err = 1'b0;
        rd(8'h44, 2, "R10");
        wr(8'h44, 2);
        rd(8'h44, 0, "R9");

        // R7 error pulse also stops
        wr(8'h30, 1);
        pulse(0, 1);
        chk("R7 run_req err", run_req, 0);
        chk("R7 ch_active err", ch_active, 0);
        wr(8'h44, 3);

        // R8 abort with engine still busy
        eng_busy = 1'b1;
        wr(8'h30, 1);
        wr(8'h30, 0);
        chk("R8 run_req", run_req, 0);
        chk("R8 active drain", ch_active, 1);
        rd(8'h40, 1, "R8");
        rd(8'h30, 0, "R8");
        repeat (4) @(negedge clk);
        chk("R8 active held", ch_active, 1);
        eng_busy = 1'b0;
        @(negedge clk);
        chk("R8 active fall", ch_active, 0);
        rd(8'h40, 0, "R8");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule